// File: doc/BRIEF.md
# Line-Interface Interrupt Status Register

This block is the second interrupt status byte of a line-interface controller. It gathers the state of the ramp generator, the level meter and four general-purpose I/O pins into one 8-bit read-only register. It raises one active-high interrupt request when any of the bits meets its own trigger rule:

- Ramp-ready and measurement-done trigger only when they go from 0 to 1.
- A debounced pin triggers on a change in either direction, unless its mask bit is set.
- A reset-seen flag is set by a hardware reset.
- The level-compare flag never triggers; it only shows the current compare result.

The raw pin levels pass through a per-pin debounce counter first. The counter length is set by an input, and it advances only on a sample tick.

While the request is asserted, the register keeps the value it held when the event arrived, so software reads the cause. Pending events stay latched until the all-registers-read strobe services them. An event that lands in the same cycle as that strobe stays pending. When the request is idle, the register follows the live status.

After reset the register reads 0x20. Once the all-read strobe is given with idle inputs, it reads 0x4F.

Top module: `lic_irq_status`

## Requirements
- R1: A synchronous reset sets irq to 1 and sets the register value to 0x20.
- R2: The bit layout is: bit 7 = level above threshold (lm_above); bit 6 = ramp ready (the inverse of ramp_active); bit 5 = reset seen; bit 4 = measurement done (lm_done); bits 3:0 = debounced pins 4..1 (pin_raw[3:0]). After reset with idle inputs (ramp idle, pins high, lm_done and lm_above low), one all_read pulse makes the register read 0x4F.
- R3: rd_data is 0x00 whenever rd_strobe is low, and equals the register value when rd_strobe is high.
- R4: A 0-to-1 change of ramp ready raises irq. A 1-to-0 change does not raise irq, although the new level is visible when no interrupt is pending.
- R5: A 0-to-1 change of lm_done raises irq. A 1-to-0 change does not.
- R6: Changes of lm_above never raise irq. They are visible in bit 7 when no interrupt is pending.
- R7: A change of a debounced pin in either direction raises irq unless its pin_mask bit is 1. A masked change still shows in the data with irq left low.
- R8: A debounced pin takes a new raw level only after that level has been present on db_len consecutive sample_tick cycles. A tick that sees the old level restarts the count. A db_len of 0 behaves as 1.
- R9: Once asserted, irq stays at 1 and the register value stays frozen until an all_read pulse. An event that arrives in the same cycle as all_read keeps irq at 1, and the register then shows that event.
- R10: The reset-seen bit is cleared by the first all_read pulse and is set again only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sample_tick | input | 1 | Debounce sample enable, one cycle per sample |
| db_len | input | 4 | Debounce length in ticks (0 acts as 1) |
| pin_raw | input | 4 | Raw I/O pin levels, bit 0 = pin 1 |
| pin_mask | input | 4 | Per-pin interrupt mask, 1 = no interrupt on change |
| ramp_active | input | 1 | Ramp generator running |
| lm_done | input | 1 | Level-metering result ready |
| lm_above | input | 1 | Metering result above threshold |
| rd_strobe | input | 1 | Read select for this register |
| all_read | input | 1 | All four interrupt registers have been read |
| rd_data | output | 8 | Register read data, zero when not selected |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted pending or reset-seen flag shows at the ports in one of two ways: irq stays asserted after an all_read pulse, or irq rises without a qualifying event. The bench checks this one clock after each stimulus. A wrong edge-detector state or debounce count appears as a missing or extra interrupt, or as a read value that does not match the expected byte, on the first read after the tick or input change. A frozen-register fault shows as a read value that moves while irq is high, or that fails to pick up the same-cycle event after servicing.

// File: rtl/lic_irq_pkg.sv
package lic_irq_pkg;

    localparam int PIN_CNT   = 4;
    localparam int STAT_W    = 8;
    localparam logic [STAT_W-1:0] RESET_VALUE = 8'h20;

    typedef struct packed {
        logic                 lvl_above;   // bit 7
        logic                 ramp_rdy;    // bit 6
        logic                 rst_seen;    // bit 5
        logic                 meas_done;   // bit 4
        logic [PIN_CNT-1:0]   pins;        // bits 3:0, pin 4 down to pin 1
    } stat_t;

    // Effective debounce length: zero is treated as one tick.
    function automatic logic [4:0] eff_limit(input logic [3:0] len);
        return (len == 4'd0) ? 5'd1 : {1'b0, len};
    endfunction

endpackage

// File: rtl/lic_pin_debounce.sv
module lic_pin_debounce
    import lic_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [3:0] len,
    input  logic       raw,
    output logic       lvl_q,
    output logic       lvl_nxt
);

    logic [3:0] cnt_q;
    logic [3:0] cnt_nxt;
    logic [4:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 5'd1;

    always_comb begin
        lvl_nxt = lvl_q;
        cnt_nxt = cnt_q;
        if (tick) begin
            if (raw != lvl_q) begin
                if (cnt_inc >= eff_limit(len)) begin
                    lvl_nxt = raw;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_inc[3:0];
                end
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= raw;
            cnt_q <= '0;
        end else begin
            lvl_q <= lvl_nxt;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/lic_irq_event.sv
module lic_irq_event
    import lic_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ramp_active,
    input  logic               lm_done,
    input  logic [PIN_CNT-1:0] pin_q,
    input  logic [PIN_CNT-1:0] pin_nxt,
    input  logic [PIN_CNT-1:0] pin_mask,
    output logic               rdy_nxt,
    output logic               ev_any
);

    logic rdy_q;
    logic done_q;
    logic rdy_rise;
    logic done_rise;
    logic [PIN_CNT-1:0] pin_chg;

    assign rdy_nxt   = ~ramp_active;
    assign rdy_rise  = rdy_nxt & ~rdy_q;
    assign done_rise = lm_done & ~done_q;

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin_ev
        assign pin_chg[i] = (pin_nxt[i] ^ pin_q[i]) & ~pin_mask[i];
    end

    assign ev_any = rdy_rise | done_rise | (|pin_chg);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= ~ramp_active;
            done_q <= lm_done;
        end else begin
            rdy_q  <= rdy_nxt;
            done_q <= lm_done;
        end
    end

endmodule

// File: rtl/lic_irq_hold.sv
module lic_irq_hold
    import lic_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  all_read,
    input  logic  ev_any,
    input  stat_t live,
    output stat_t hold_q,
    output logic  irq
);

    logic pend_q;
    logic rstat_q;
    logic load;
    stat_t live_clean;

    assign irq  = pend_q | rstat_q;
    assign load = ~irq | all_read;

    always_comb begin
        live_clean          = live;
        live_clean.rst_seen = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= stat_t'(RESET_VALUE);
            pend_q  <= 1'b0;
            rstat_q <= 1'b1;
        end else begin
            rstat_q <= rstat_q & ~all_read;
            pend_q  <= (pend_q & ~all_read) | ev_any;
            if (load) begin
                hold_q <= live_clean;
            end
        end
    end

endmodule

// File: rtl/lic_irq_status.sv
module lic_irq_status
    import lic_irq_pkg::*;
#(
    parameter int DB_W = 4
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_tick,
    input  logic [DB_W-1:0]     db_len,
    input  logic [PIN_CNT-1:0]  pin_raw,
    input  logic [PIN_CNT-1:0]  pin_mask,
    input  logic                ramp_active,
    input  logic                lm_done,
    input  logic                lm_above,
    input  logic                rd_strobe,
    input  logic                all_read,
    output logic [STAT_W-1:0]   rd_data,
    output logic                irq
);

    logic [PIN_CNT-1:0] pin_q;
    logic [PIN_CNT-1:0] pin_nxt;
    logic               rdy_nxt;
    logic               ev_any;
    stat_t              live;
    stat_t              hold;
    logic [STAT_W-1:0]  hold_bits;

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_db
        lic_pin_debounce u_db (
            .clk     (clk),
            .rst     (rst),
            .tick    (sample_tick),
            .len     (db_len[3:0]),
            .raw     (pin_raw[i]),
            .lvl_q   (pin_q[i]),
            .lvl_nxt (pin_nxt[i])
        );
    end

    lic_irq_event u_ev (
        .clk         (clk),
        .rst         (rst),
        .ramp_active (ramp_active),
        .lm_done     (lm_done),
        .pin_q       (pin_q),
        .pin_nxt     (pin_nxt),
        .pin_mask    (pin_mask),
        .rdy_nxt     (rdy_nxt),
        .ev_any      (ev_any)
    );

    always_comb begin
        live.lvl_above = lm_above;
        live.ramp_rdy  = rdy_nxt;
        live.rst_seen  = 1'b0;
        live.meas_done = lm_done;
        live.pins      = pin_nxt;
    end

    lic_irq_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .all_read (all_read),
        .ev_any   (ev_any),
        .live     (live),
        .hold_q   (hold),
        .irq      (irq)
    );

    assign hold_bits = hold;
    assign rd_data   = rd_strobe ? hold_bits : '0;

endmodule

// File: rtl/lic_irq_status_chk.sv
module lic_irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       all_read,
    input logic [7:0] hold_q
);

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (irq && hold_q == 8'h20));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !all_read) |=> irq);

    // R9
    irq_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(all_read));

    // R9
    frozen_value_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !all_read) |=> $stable(hold_q));

    // R10
    rstat_gone_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_q[5] |=> !hold_q[5]);

    // R10
    rstat_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q[5] |-> irq);

endmodule

bind lic_irq_status lic_irq_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .all_read (all_read),
    .hold_q   (hold_bits)
);

// File: tb/sim_lic_irq_status.sv
`timescale 1ns/1ps
module sim_lic_irq_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic [3:0] db_len = 4'd1;
    logic [3:0] pin_raw = 4'hF;
    logic [3:0] pin_mask = 4'h0;
    logic       ramp_active = 1'b0;
    logic       lm_done = 1'b0;
    logic       lm_above = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       all_read = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lic_irq_status u0 (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .db_len(db_len),
        .pin_raw(pin_raw), .pin_mask(pin_mask), .ramp_active(ramp_active),
        .lm_done(lm_done), .lm_above(lm_above), .rd_strobe(rd_strobe),
        .all_read(all_read), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [7:0] exp_data, input logic exp_irq);
        logic [7:0] v;
        rd_strobe = 1'b1;
        #1;
        v = rd_data;
        rd_strobe = 1'b0;
        check(req, v, exp_data);
        check(req, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    task automatic ack();
        all_read = 1'b1;
        step();
        all_read = 1'b0;
        step();
    endtask

    task automatic tick();
        sample_tick = 1'b1;
        step();
        sample_tick = 1'b0;
        step();
    endtask

    task automatic t_reset();
        step();
        read_check("R1 reset", 8'h20, 1'b1);
        ack();
        read_check("R2 R10 after all_read", 8'h4F, 1'b0);
    endtask

    task automatic t_read_gate();
        #1;
        check("R3 gated read", rd_data, 8'h00);
    endtask

    task automatic t_ramp();
        ramp_active = 1'b1;
        step();
        read_check("R4 ramp start", 8'h0F, 1'b0);
        ramp_active = 1'b0;
        step();
        read_check("R4 ramp ready rise", 8'h4F, 1'b1);
        ack();
        read_check("R4 serviced", 8'h4F, 1'b0);
    endtask

    task automatic t_done();
        lm_done = 1'b1;
        step();
        read_check("R5 done rise", 8'h5F, 1'b1);
        ack();
        lm_done = 1'b0;
        step();
        read_check("R5 done fall", 8'h4F, 1'b0);
    endtask

    task automatic t_level();
        lm_above = 1'b1;
        step();
        read_check("R6 level high", 8'hCF, 1'b0);
        lm_above = 1'b0;
        step();
        read_check("R6 level low", 8'h4F, 1'b0);
    endtask

    task automatic t_pins();
        db_len = 4'd1;
        pin_raw = 4'b1101;
        tick();
        read_check("R7 pin2 falls", 8'h4D, 1'b1);
        ack();
        pin_raw = 4'b1111;
        tick();
        read_check("R7 pin2 rises", 8'h4F, 1'b1);
        ack();
        pin_mask = 4'b0010;
        pin_raw = 4'b1101;
        tick();
        read_check("R7 masked change", 8'h4D, 1'b0);
        pin_raw = 4'b1111;
        tick();
        read_check("R7 masked restore", 8'h4F, 1'b0);
        pin_mask = 4'b0000;
    endtask

    task automatic t_debounce();
        db_len = 4'd3;
        pin_raw = 4'b1110;
        tick();
        tick();
        read_check("R8 two ticks", 8'h4F, 1'b0);
        tick();
        read_check("R8 third tick", 8'h4E, 1'b1);
        ack();
        pin_raw = 4'b1111;
        tick();
        tick();
        pin_raw = 4'b1110;
        tick();
        pin_raw = 4'b1111;
        tick();
        tick();
        read_check("R8 restarted count", 8'h4E, 1'b0);
        tick();
        read_check("R8 restarted done", 8'h4F, 1'b1);
        ack();
        db_len = 4'd0;
        pin_raw = 4'b0111;
        tick();
        read_check("R8 zero length", 8'h47, 1'b1);
        ack();
        pin_raw = 4'b1111;
        tick();
        ack();
        read_check("R8 restored", 8'h4F, 1'b0);
    endtask

    task automatic t_freeze();
        lm_done = 1'b1;
        step();
        lm_above = 1'b1;
        step();
        read_check("R9 frozen", 8'h5F, 1'b1);
        ack();
        read_check("R9 released", 8'hDF, 1'b0);
        lm_above = 1'b0;
        lm_done = 1'b0;
        step();
        lm_done = 1'b1;
        step();
        lm_done = 1'b0;
        step();
        read_check("R9 frozen on fall", 8'h5F, 1'b1);
        all_read = 1'b1;
        lm_done = 1'b1;
        step();
        all_read = 1'b0;
        read_check("R9 same-cycle event", 8'h5F, 1'b1);
        ack();
        read_check("R9 R10 final ack", 8'h5F, 1'b0);
        lm_done = 1'b0;
        step();
        read_check("R10 no rstat", 8'h4F, 1'b0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_read_gate();
        t_ramp();
        t_done();
        t_level();
        t_pins();
        t_debounce();
        t_freeze();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule